// File: doc/BRIEF.md
# Three-Level PWM Half-Bridge Gate Sequencer

This block is the clocked control core of a synchronous buck half-bridge driver. It turns a three-level PWM command and a three-level enable command into two gate enables, one for the high-side switch and one for the low-side switch. Dead time is closed by feedback, not by a fixed delay. Before a gate is allowed to turn on, a comparator flag has to report that the opposite gate has discharged. A programmable non-overlap count must then also run out.

The mid PWM level selects diode emulation. The low-side switch turns on and stays on through a blanking window plus a debounce window. After that it is turned off when the zero-current comparator fires, and it stays off until PWM leaves the mid level. The enable command can run the driver, shut it off, or hold both gates off at its mid level, which is useful for body-diode braking. A supply-good flag gates everything. Each new rise of that flag starts a calibration hold of a fixed cycle count, and during the hold both gates stay off.

Each command arrives as a 2-bit code: `00` low, `01` mid, `10` high, and `11` handled as mid. Every input passes through a two-flop synchroniser. A decision is therefore made on the third rising clock edge after an input changes. The gate outputs are decoded straight from the state register.

Top module: `halfBridgeSeq`

## Requirements
- R1: `hsGate` and `lsGate` are never both 1 in the same cycle.
- R2: With enable high, PWM code `10` turns `lsGate` off on the third edge after the code changes. `hsGate` rises on the DEAD_CYC-th consecutive edge at which the synchronised `lsGateLow` is 1.
- R3: With enable high, PWM code `00` turns `hsGate` off on the third edge after the code changes. `lsGate` rises on the DEAD_CYC-th consecutive edge at which the synchronised `hsGateLow` is 1.
- R4: PWM mid entered while the high side is on or idle turns the high side off. The low side then turns on after the same sense-plus-DEAD_CYC rule as R3. If the low side was already on, it stays on without a gap.
- R5: In PWM mid, `zeroCur` is not examined for BLANK_CYC+DEBOUNCE_CYC edges after the low side turns on. With `zeroCur` held at 1, `lsGate` is therefore high for BLANK_CYC+DEBOUNCE_CYC+1 cycles.
- R6: After that window, a synchronised `zeroCur` of 1 drops `lsGate` on the third edge after it is applied. `lsGate` stays low while PWM remains mid, even if `zeroCur` returns to 0.
- R7: In PWM mid after the window, `lsGate` stays high for as long as `zeroCur` stays 0.
- R8: PWM code `11` behaves exactly like the mid code `01`.
- R9: An enable code other than `10` (that is `00`, `01` or `11`) forces both gates low by the third edge. Returning to `10` resumes normal PWM sequencing.
- R10: Both gates are low from the third edge after `supplyOk` is sampled low.
- R11: A rise of `supplyOk` raises `calBusy` on the third edge, for exactly CAL_CYC cycles. During those cycles both gates stay low and PWM is ignored. Normal sequencing starts on the following edge.
- R12: After reset, both gates and `calBusy` are low, and they stay low until `supplyOk` rises.
- R13: Leaving PWM mid clears the zero-current latch. PWM low turns the low side back on by the R3 rule, and a later return to mid opens a fresh blanking window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwmCode | input | 2 | PWM level code: 00 low, 01 mid, 10 high, 11 mid |
| enCode | input | 2 | Enable level code: 10 run, any other code gates off |
| supplyOk | input | 1 | Supply-good flag |
| lsGateLow | input | 1 | Low-side gate sensed below 1 V |
| hsGateLow | input | 1 | High-side gate-to-switch sensed below 1 V |
| zeroCur | input | 1 | Inductor current has reached zero |
| hsGate | output | 1 | High-side gate enable |
| lsGate | output | 1 | Low-side gate enable |
| calBusy | output | 1 | Calibration hold in progress |

## Verification
Every internal state has a distinct and fixed timing signature at the gate pins. A wrong state or a miscounted timer shows up within a few cycles as a gate edge in the wrong cycle. Examples are a high-side rise that comes earlier or later than three plus sense delay plus non-overlap edges, or a diode-emulation pulse of the wrong width. A lost zero-current latch shows up as the low side turning back on when the comparator drops. A stale counter shortens the next dead time. A mis-sequenced calibration shows up as a `calBusy` pulse that is not CAL_CYC cycles long.

// File: rtl/hbPkg.sv
package hbPkg;

  typedef enum logic [1:0] {
    LVL_LO  = 2'd0,
    LVL_MID = 2'd1,
    LVL_HI  = 2'd2
  } level_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CAL,
    S_OFF,
    S_HS_WAIT,
    S_HS_ON,
    S_LS_WAIT,
    S_LS_ON,
    S_DE_WAIT,
    S_DE_BLANK,
    S_DE_WATCH,
    S_DE_DONE
  } seqState_e;

  // strobes from control to the interval counter
  typedef struct packed {
    logic clr;
    logic inc;
  } tmrCmd_t;

  // limit matches reported back by the counter
  typedef struct packed {
    logic dead;
    logic hold;
    logic cal;
  } tmrHit_t;

  // code 11 is treated as the safe mid level
  function automatic level_e decodeLevel(input logic [1:0] code);
    case (code)
      2'b00:   return LVL_LO;
      2'b10:   return LVL_HI;
      default: return LVL_MID;
    endcase
  endfunction

endpackage

// File: rtl/hbSync.sv
module hbSync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe[0] <= '0;
    else       pipe[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe[s] <= '0;
      else       pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/hbTimer.sv
module hbTimer
  import hbPkg::*;
#(
  parameter int DEAD_CYC = 8,
  parameter int HOLD_CYC = 43,
  parameter int CAL_CYC  = 3000000
) (
  input  logic    clk,
  input  logic    rstN,
  input  tmrCmd_t cmd,
  output tmrHit_t hit
);

  localparam int MAX_A = (DEAD_CYC > HOLD_CYC) ? DEAD_CYC : HOLD_CYC;
  localparam int MAX_L = (MAX_A > CAL_CYC) ? MAX_A : CAL_CYC;
  localparam int CNT_W = $clog2(MAX_L + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cnt <= '0;
    else if (cmd.clr) cnt <= '0;
    else if (cmd.inc) cnt <= cnt + 1'b1;
  end

  assign hit.dead = (cnt == CNT_W'(DEAD_CYC - 1));
  assign hit.hold = (cnt == CNT_W'(HOLD_CYC - 1));
  assign hit.cal  = (cnt == CNT_W'(CAL_CYC - 1));

endmodule

// File: rtl/hbCtrl.sv
module hbCtrl
  import hbPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  level_e  pwmLvl,
  input  level_e  enLvl,
  input  logic    supplyQ,
  input  logic    lsLowQ,
  input  logic    hsLowQ,
  input  logic    zeroQ,
  input  tmrHit_t hit,
  output tmrCmd_t cmd,
  output logic    hsGate,
  output logic    lsGate,
  output logic    calBusy
);

  seqState_e st, nxt;
  logic      supplyPrev;
  logic      supplyRise;
  logic      waiting;
  logic      senseOk;

  assign supplyRise = supplyQ & ~supplyPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st         <= S_IDLE;
      supplyPrev <= 1'b0;
    end else begin
      st         <= nxt;
      supplyPrev <= supplyQ;
    end
  end

  // which sense flag gates the current wait state
  always_comb begin
    waiting = 1'b0;
    senseOk = 1'b0;
    case (st)
      S_HS_WAIT: begin waiting = 1'b1; senseOk = lsLowQ; end
      S_LS_WAIT,
      S_DE_WAIT: begin waiting = 1'b1; senseOk = hsLowQ; end
      default:   ;
    endcase
  end

  always_comb begin
    nxt = st;
    if (!supplyQ) begin
      nxt = S_IDLE;
    end else if (supplyRise) begin
      nxt = S_CAL;
    end else begin
      case (st)
        S_IDLE: nxt = S_IDLE;
        S_CAL:  if (hit.cal) nxt = S_OFF;
        default: begin
          if (enLvl != LVL_HI) begin
            nxt = S_OFF;
          end else begin
            case (pwmLvl)
              LVL_HI: begin
                if (st == S_HS_ON)                              nxt = S_HS_ON;
                else if (st == S_HS_WAIT && lsLowQ && hit.dead) nxt = S_HS_ON;
                else                                            nxt = S_HS_WAIT;
              end
              LVL_LO: begin
                if (st == S_LS_ON)                              nxt = S_LS_ON;
                else if (st inside {S_DE_BLANK, S_DE_WATCH})    nxt = S_LS_ON;
                else if (st == S_LS_WAIT && hsLowQ && hit.dead) nxt = S_LS_ON;
                else                                            nxt = S_LS_WAIT;
              end
              default: begin
                case (st)
                  S_DE_WAIT:  if (hsLowQ && hit.dead) nxt = S_DE_BLANK;
                  S_LS_ON:    nxt = S_DE_BLANK;
                  S_DE_BLANK: if (hit.hold) nxt = S_DE_WATCH;
                  S_DE_WATCH: if (zeroQ) nxt = S_DE_DONE;
                  S_DE_DONE:  nxt = S_DE_DONE;
                  default:    nxt = S_DE_WAIT;
                endcase
              end
            endcase
          end
        end
      endcase
    end
  end

  always_comb begin
    cmd.clr = (nxt != st) || (waiting && !senseOk);
    cmd.inc = (waiting && senseOk) || (st == S_DE_BLANK) || (st == S_CAL);
  end

  assign hsGate  = (st == S_HS_ON);
  assign lsGate  = (st inside {S_LS_ON, S_DE_BLANK, S_DE_WATCH});
  assign calBusy = (st == S_CAL);

endmodule

// File: rtl/halfBridgeSeq.sv
module halfBridgeSeq
  import hbPkg::*;
#(
  parameter int DEAD_CYC     = 8,
  parameter int BLANK_CYC    = 35,
  parameter int DEBOUNCE_CYC = 8,
  parameter int CAL_CYC      = 3000000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] pwmCode,
  input  logic [1:0] enCode,
  input  logic       supplyOk,
  input  logic       lsGateLow,
  input  logic       hsGateLow,
  input  logic       zeroCur,
  output logic       hsGate,
  output logic       lsGate,
  output logic       calBusy
);

  localparam int HOLD_CYC = BLANK_CYC + DEBOUNCE_CYC;
  localparam int IN_W     = 8;

  logic [IN_W-1:0] rawIn, syncIn;
  tmrCmd_t         cmd;
  tmrHit_t         hit;

  assign rawIn = {pwmCode, enCode, supplyOk, lsGateLow, hsGateLow, zeroCur};

  hbSync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .d    (rawIn),
    .q    (syncIn)
  );

  hbTimer #(.DEAD_CYC(DEAD_CYC), .HOLD_CYC(HOLD_CYC), .CAL_CYC(CAL_CYC)) u_timer (
    .clk  (clk),
    .rstN (rstN),
    .cmd  (cmd),
    .hit  (hit)
  );

  hbCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .pwmLvl  (decodeLevel(syncIn[7:6])),
    .enLvl   (decodeLevel(syncIn[5:4])),
    .supplyQ (syncIn[3]),
    .lsLowQ  (syncIn[2]),
    .hsLowQ  (syncIn[1]),
    .zeroQ   (syncIn[0]),
    .hit     (hit),
    .cmd     (cmd),
    .hsGate  (hsGate),
    .lsGate  (lsGate),
    .calBusy (calBusy)
  );

endmodule

// File: rtl/hbChecker.sv
module hbChecker #(
  parameter int CAL_CYC = 3000000
) (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] enCode,
  input logic       supplyOk,
  input logic       lsGateLow,
  input logic       hsGateLow,
  input logic       hsGate,
  input logic       lsGate,
  input logic       calBusy
);

  localparam int RUN_W = $clog2(CAL_CYC + 1);

  logic [RUN_W-1:0] calRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        calRun <= '0;
    else if (calBusy) calRun <= calRun + 1'b1;
    else              calRun <= '0;
  end

  assert_excl_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(hsGate && lsGate));

  assert_hs_sense_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsGate) |-> $past(lsGateLow, 3));

  assert_ls_sense_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lsGate) |-> $past(hsGateLow, 3));

  assert_en_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enCode, 3) != 2'b10) |-> (!hsGate && !lsGate));

  assert_supply_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(supplyOk, 3) |-> (!hsGate && !lsGate));

  assert_cal_len_R11: assert property (@(posedge clk) disable iff (!rstN)
    calBusy |-> (calRun < RUN_W'(CAL_CYC)));

endmodule

bind halfBridgeSeq hbChecker #(.CAL_CYC(CAL_CYC)) u_hbChecker (
  .clk       (clk),
  .rstN      (rstN),
  .enCode    (enCode),
  .supplyOk  (supplyOk),
  .lsGateLow (lsGateLow),
  .hsGateLow (hsGateLow),
  .hsGate    (hsGate),
  .lsGate    (lsGate),
  .calBusy   (calBusy)
);

// File: tb/test_halfBridgeSeq.sv
module test_halfBridgeSeq;

  localparam int CLK_PERIOD = 10;
  localparam int DEAD  = 3;
  localparam int BLANK = 4;
  localparam int DEB   = 2;
  localparam int HOLD  = BLANK + DEB;
  localparam int CAL   = 40;
  localparam int SD    = 2;              // sense delay of the gate model
  localparam int LAT   = 3;              // two sync flops plus state edge
  localparam int FAR   = LAT + SD + 2 + DEAD;
  localparam int NEAR  = LAT + DEAD;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] pwmCode = 2'b00;
  logic [1:0] enCode = 2'b10;
  logic       supplyOk = 1'b0;
  logic       zeroCur = 1'b0;
  logic       hsGate, lsGate, calBusy;
  logic [SD-1:0] hsHist, lsHist;
  logic       lsGateLow, hsGateLow;
  int         total = 0;
  int         bad = 0;

  assign lsGateLow = !lsHist[SD-1];
  assign hsGateLow = !hsHist[SD-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  // gate sense model: comparator follows the gate SD cycles late
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsHist <= '0;
      lsHist <= '0;
    end else begin
      hsHist <= {hsHist[SD-2:0], hsGate};
      lsHist <= {lsHist[SD-2:0], lsGate};
    end
  end

  halfBridgeSeq #(
    .DEAD_CYC(DEAD), .BLANK_CYC(BLANK), .DEBOUNCE_CYC(DEB), .CAL_CYC(CAL)
  ) i_halfBridgeSeq (
    .clk(clk), .rstN(rstN), .pwmCode(pwmCode), .enCode(enCode),
    .supplyOk(supplyOk), .lsGateLow(lsGateLow), .hsGateLow(hsGateLow),
    .zeroCur(zeroCur), .hsGate(hsGate), .lsGate(lsGate), .calBusy(calBusy)
  );

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [1:0] lvlCode(input int l, input bit alt);
    if (l == 0) return 2'b00;
    if (l == 2) return 2'b10;
    return alt ? 2'b11 : 2'b01;
  endfunction

  // expected {hs, ls} k negedges after PWM moves from steady 'from' to 'to'
  // levels: 0 low, 1 mid (zero current present), 2 high
  function automatic logic [1:0] expGates(input int from, input int to, input int k);
    logic hs, ls;
    hs = 1'b0;
    ls = 1'b0;
    if (from == to) begin
      hs = (to == 2);
      ls = (to == 0);
    end else if (to == 2) begin
      hs = (k >= ((from == 0) ? FAR : NEAR));
      ls = (from == 0) && (k < LAT);
    end else if (to == 0) begin
      ls = (k >= ((from == 2) ? FAR : NEAR));
      hs = (from == 2) && (k < LAT);
    end else if (from == 2) begin
      hs = (k < LAT);
      ls = (k >= FAR) && (k < FAR + HOLD + 1);
    end else begin
      ls = (k < LAT + HOLD + 1);
    end
    return {hs, ls};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    chk("R12 reset", {hsGate, lsGate, calBusy}, 3'b000);
    rstN = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      step(1);
      chk("R12 idle", {hsGate, lsGate, calBusy}, 3'b000);
    end

    // calibration hold; PWM toggled inside it is ignored
    supplyOk = 1'b1;
    for (int k = 1; k <= CAL + DEAD + 6; k++) begin
      step(1);
      chk($sformatf("R11 cal k=%0d", k), {hsGate, lsGate, calBusy},
          {1'b0, 1'(k >= 4 + CAL + DEAD), 1'(k >= 3 && k < 3 + CAL)});
      if (k == 5)  pwmCode = 2'b10;
      if (k == 15) pwmCode = 2'b00;
    end

    // level-transition sweep, second pass uses code 11 as mid
    zeroCur = 1'b1;
    for (int pass = 0; pass < 2; pass++) begin
      for (int from = 0; from < 3; from++) begin
        for (int to = 0; to < 3; to++) begin
          pwmCode = lvlCode(from, pass == 1);
          step(25);
          pwmCode = lvlCode(to, pass == 1);
          for (int k = 1; k <= 24; k++) begin
            string rq;
            step(1);
            rq = (pass == 1) ? "R8" : (to == 2) ? "R2" : (to == 0) ? "R3" :
                 (k <= LAT + HOLD) ? "R4" : "R5";
            chk($sformatf("%s sweep %0d->%0d k=%0d", rq, from, to, k),
                {hsGate, lsGate, calBusy}, {expGates(from, to, k), 1'b0});
            chk("R1 exclusive", {1'b0, 1'b0, hsGate & lsGate}, 3'b000);
          end
        end
      end
    end

    // blanking ignores a comparator pulse; low side held while current flows
    pwmCode = 2'b00;
    zeroCur = 1'b0;
    step(25);
    pwmCode = 2'b01;
    for (int k = 1; k <= 30; k++) begin
      step(1);
      chk($sformatf("%s mid hold k=%0d", (k <= 9) ? "R5" : "R7", k),
          {hsGate, lsGate, calBusy}, 3'b010);
      if (k == 4) zeroCur = 1'b1;
      if (k == 5) zeroCur = 1'b0;
    end
    zeroCur = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      step(1);
      chk($sformatf("R6 zero hit k=%0d", k), {hsGate, lsGate, calBusy},
          {1'b0, 1'(k < 3), 1'b0});
    end
    zeroCur = 1'b0;
    for (int k = 1; k <= 20; k++) begin
      step(1);
      chk("R6 latched off", {hsGate, lsGate, calBusy}, 3'b000);
    end
    pwmCode = 2'b00;
    for (int k = 1; k <= 8; k++) begin
      step(1);
      chk($sformatf("R13 exit mid k=%0d", k), {hsGate, lsGate, calBusy},
          {1'b0, 1'(k >= NEAR), 1'b0});
    end
    pwmCode = 2'b01;
    for (int k = 1; k <= 20; k++) begin
      step(1);
      chk("R13 new window", {hsGate, lsGate, calBusy}, 3'b010);
    end

    // enable codes other than 10 gate both outputs off
    pwmCode = 2'b10;
    step(25);
    for (int e = 0; e < 3; e++) begin
      enCode = (e == 0) ? 2'b01 : (e == 1) ? 2'b00 : 2'b11;
      for (int k = 1; k <= 20; k++) begin
        step(1);
        chk($sformatf("R9 en=%b k=%0d", enCode, k), {hsGate, lsGate, calBusy},
            {1'(k < LAT), 1'b0, 1'b0});
      end
      enCode = 2'b10;
      for (int k = 1; k <= 8; k++) begin
        step(1);
        chk($sformatf("R9 resume k=%0d", k), {hsGate, lsGate, calBusy},
            {1'(k >= NEAR), 1'b0, 1'b0});
      end
    end

    // supply loss
    supplyOk = 1'b0;
    for (int k = 1; k <= 10; k++) begin
      step(1);
      chk($sformatf("R10 supply low k=%0d", k), {hsGate, lsGate, calBusy},
          {1'(k < LAT), 1'b0, 1'b0});
      if (k == 5) pwmCode = 2'b00;
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule